// File: doc/BRIEF.md
# Glitch-free clock rate selector

This block sets the rate of the core's machine cycle from one of several clock sources. A 2-bit mode field picks one of four rates. The reset default is the crystal divided by four. The other modes are a very slow power-saving rate and two rates taken from the outputs of an external frequency multiplier (2X and 4X). Every clock source reaches the block as a one-cycle tick strobe in a single fast sampling domain. The block emits a one-cycle machine-cycle enable and reports the mode that the current machine cycle runs in. A new mode is applied only where a machine cycle ends, so no cycle is ever cut short.

A sequencer controls which mode changes are allowed. A move between two modes must go through divide-by-4. Any other write is refused, the setting is kept, and a sticky error flag is raised. A multiplier mode is applied only while the multiplier reports lock.

On a stop request the machine-cycle enable goes quiet, and the crystal is assumed halted. A wake request moves the core onto a ring oscillator at once. The block then counts crystal ticks up to a programmable stable count and returns to the crystal at the next machine-cycle boundary.

Top module: `clk_rate_sel`

## Requirements
- R1: After synchronous reset, cur_mode is 2'b10 (divide-by-4), err_flag is 0 and on_ring is 0.
- R2: Mode encoding and machine-cycle period, in ticks of the source: 2'b10 gives one mc_en per 4 xtal ticks; 2'b11 gives one per 1024 xtal ticks (256 times slower); 2'b01 gives one per 4 ticks of pll2_tick (2X); 2'b00 gives one per 4 ticks of pll4_tick (4X).
- R3: A write is accepted only if the old or the new value is 2'b10, or if both values are the same. Any other write leaves the requested mode unchanged.
- R4: A refused write sets err_flag. err_flag stays set until err_clr is pulsed. If a refusal and err_clr arrive in the same cycle, the set wins.
- R5: While pll_lock is 0, a requested multiplier mode (2'b00 or 2'b01) runs as 2'b10. The multiplier rate takes over at the first boundary after lock is present.
- R6: cur_mode changes only at a machine-cycle boundary, in the same cycle as an mc_en pulse. The cycle that is running when a write arrives completes at its old length.
- R7: After stop_req in the running state, no mc_en pulse occurs after the one in flight until wake_req.
- R8: wake_req while stopped sets on_ring on the next cycle. The machine cycle then runs at one mc_en per 4 ring_tick, reported as mode 2'b10.
- R9: The source returns from the ring to the crystal only after stable_cnt xtal ticks have been counted since the wake, at a machine-cycle boundary. The requested mode then applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Mode field write strobe |
| wr_mode | input | 2 | Mode value written |
| err_clr | input | 1 | Clears the sticky error flag |
| pll_lock | input | 1 | Multiplier lock indication |
| xtal_tick | input | 1 | Crystal source tick |
| pll2_tick | input | 1 | 2X multiplier tick |
| pll4_tick | input | 1 | 4X multiplier tick |
| ring_tick | input | 1 | Ring oscillator tick |
| stop_req | input | 1 | Enter stop |
| wake_req | input | 1 | Leave stop |
| stable_cnt | input | STAB_W | Crystal ticks required before leaving the ring |
| mc_en | output | 1 | One-cycle machine-cycle enable |
| cur_mode | output | 2 | Mode of the current machine cycle |
| on_ring | output | 1 | Ring oscillator is the source |
| err_flag | output | 1 | Sticky refused-write flag |

## Verification
The bench goes after the boundary rule by writing a new mode part-way through a 4096-clock slow cycle. A design that switched at once would deliver a shortened cycle instead of the expected full-length one. Direct writes between two non-default modes are tried from the slow mode and from 4X. A design without the pass-through rule would change rate and leave the error flag clear. A 4X request is made without multiplier lock, so a design that ignored lock would run four times too fast. Across stop and wake, the bench holds the crystal off, counts quiet cycles, and measures how long the ring stays selected. A design that returned early would fail the stable-count window, and one that kept pulsing during stop would be caught by the quiet-cycle count.

// File: rtl/clk_sel_pkg.sv
package clk_sel_pkg;
  typedef enum logic [1:0] {
    MD_X4   = 2'b00,
    MD_X2   = 2'b01,
    MD_DIV4 = 2'b10,
    MD_SLOW = 2'b11
  } clk_mode_e;

  typedef enum logic [1:0] {
    PH_RUN  = 2'b00,
    PH_STOP = 2'b01,
    PH_RING = 2'b10
  } pwr_ph_e;
endpackage

// File: rtl/clk_mode_ctl.sv
module clk_mode_ctl
  import clk_sel_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  logic [1:0] wr_mode,
  input  logic      err_clr,
  input  logic      pll_lock,
  output clk_mode_e req_mode,
  output clk_mode_e eff_mode,
  output logic      err_flag
);
  clk_mode_e new_mode;
  logic      legal;

  assign new_mode = clk_mode_e'(wr_mode);
  assign legal = (new_mode == req_mode) || (new_mode == MD_DIV4) ||
                 (req_mode == MD_DIV4);

  // multiplier modes fall back to divide-by-4 until lock
  always_comb begin
    eff_mode = req_mode;
    if (!pll_lock && ((req_mode == MD_X4) || (req_mode == MD_X2)))
      eff_mode = MD_DIV4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_mode <= MD_DIV4;
      err_flag <= 1'b0;
    end else begin
      if (wr_en && legal)
        req_mode <= new_mode;
      if (wr_en && !legal)
        err_flag <= 1'b1;
      else if (err_clr)
        err_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/clk_wake_ctl.sv
module clk_wake_ctl
  import clk_sel_pkg::*;
#(
  parameter int STAB_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_req,
  input  logic              wake_req,
  input  logic              xtal_tick,
  input  logic [STAB_W-1:0] stable_cnt,
  input  logic              mc_bound,
  output pwr_ph_e           phase,
  output logic              xtal_ok
);
  logic [STAB_W-1:0] stab_q;

  assign xtal_ok = (stab_q >= stable_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_RUN;
      stab_q <= '0;
    end else begin
      unique case (phase)
        PH_RUN: begin
          if (stop_req) phase <= PH_STOP;
        end
        PH_STOP: begin
          if (wake_req) begin
            phase  <= PH_RING;
            stab_q <= '0;
          end
        end
        PH_RING: begin
          if (xtal_tick && !xtal_ok)
            stab_q <= stab_q + 1'b1;
          if (mc_bound && xtal_ok)
            phase <= PH_RUN;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end
endmodule

// File: rtl/clk_cycle_gen.sv
module clk_cycle_gen
  import clk_sel_pkg::*;
#(
  parameter int STD_DIV    = 4,
  parameter int PMM_FACTOR = 256
) (
  input  logic      clk,
  input  logic      rst,
  input  pwr_ph_e   phase,
  input  clk_mode_e eff_mode,
  input  logic      xtal_ok,
  input  logic      xtal_tick,
  input  logic      pll2_tick,
  input  logic      pll4_tick,
  input  logic      ring_tick,
  output logic      mc_bound,
  output logic      mc_en,
  output clk_mode_e cur_mode
);
  localparam int PMM_DIV = STD_DIV * PMM_FACTOR;
  localparam int CW      = (PMM_DIV > 2) ? $clog2(PMM_DIV) : 1;
  localparam logic [CW-1:0] LIM_STD = CW'(STD_DIV - 1);
  localparam logic [CW-1:0] LIM_PMM = CW'(PMM_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          src_tick;

  always_comb begin
    src_tick = 1'b0;
    case (phase)
      PH_RING: src_tick = ring_tick;
      PH_RUN: begin
        case (cur_mode)
          MD_X4:   src_tick = pll4_tick;
          MD_X2:   src_tick = pll2_tick;
          default: src_tick = xtal_tick;
        endcase
      end
      default: src_tick = 1'b0;
    endcase
  end

  assign limit    = ((phase == PH_RUN) && (cur_mode == MD_SLOW)) ? LIM_PMM : LIM_STD;
  assign mc_bound = src_tick && (cnt_q == limit) && (phase != PH_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      mc_en    <= 1'b0;
      cur_mode <= MD_DIV4;
    end else begin
      mc_en <= mc_bound;
      if (phase == PH_STOP) begin
        cnt_q <= '0;
      end else if (mc_bound) begin
        cnt_q    <= '0;
        cur_mode <= ((phase == PH_RUN) || xtal_ok) ? eff_mode : MD_DIV4;
      end else if (src_tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_rate_sel.sv
module clk_rate_sel
  import clk_sel_pkg::*;
#(
  parameter int STD_DIV    = 4,
  parameter int PMM_FACTOR = 256,
  parameter int STAB_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_mode,
  input  logic              err_clr,
  input  logic              pll_lock,
  input  logic              xtal_tick,
  input  logic              pll2_tick,
  input  logic              pll4_tick,
  input  logic              ring_tick,
  input  logic              stop_req,
  input  logic              wake_req,
  input  logic [STAB_W-1:0] stable_cnt,
  output logic              mc_en,
  output logic [1:0]        cur_mode,
  output logic              on_ring,
  output logic              err_flag
);
  clk_mode_e req_mode;
  clk_mode_e eff_mode;
  clk_mode_e cur_mode_e;
  pwr_ph_e   phase;
  logic      xtal_ok;
  logic      mc_bound;

  clk_mode_ctl u_mode (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_mode  (wr_mode),
    .err_clr  (err_clr),
    .pll_lock (pll_lock),
    .req_mode (req_mode),
    .eff_mode (eff_mode),
    .err_flag (err_flag)
  );

  clk_wake_ctl #(.STAB_W(STAB_W)) u_wake (
    .clk        (clk),
    .rst        (rst),
    .stop_req   (stop_req),
    .wake_req   (wake_req),
    .xtal_tick  (xtal_tick),
    .stable_cnt (stable_cnt),
    .mc_bound   (mc_bound),
    .phase      (phase),
    .xtal_ok    (xtal_ok)
  );

  clk_cycle_gen #(.STD_DIV(STD_DIV), .PMM_FACTOR(PMM_FACTOR)) u_cyc (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .eff_mode  (eff_mode),
    .xtal_ok   (xtal_ok),
    .xtal_tick (xtal_tick),
    .pll2_tick (pll2_tick),
    .pll4_tick (pll4_tick),
    .ring_tick (ring_tick),
    .mc_bound  (mc_bound),
    .mc_en     (mc_en),
    .cur_mode  (cur_mode_e)
  );

  assign cur_mode = cur_mode_e;
  assign on_ring  = (phase == PH_RING);
endmodule

// File: rtl/clk_rate_sel_chk.sv
module clk_rate_sel_chk
  import clk_sel_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      wr_en,
  input logic [1:0] wr_mode,
  input clk_mode_e req_mode,
  input logic      err_clr,
  input logic      err_flag,
  input logic [1:0] cur_mode,
  input logic      mc_en,
  input logic      pll_lock,
  input pwr_ph_e   phase,
  input logic      wake_req,
  input logic      on_ring
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cur_mode == 2'b10 && !err_flag && !on_ring));

  p_reject_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(wr_mode == req_mode || wr_mode == 2'b10 || req_mode == MD_DIV4))
    |=> ($stable(req_mode) && err_flag));

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag);

  p_lock_needed_r5: assert property (@(posedge clk) disable iff (rst)
    (mc_en && !$past(pll_lock)) |-> cur_mode[1]);

  p_mode_at_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_mode) |-> mc_en);

  p_stop_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STOP && $past(phase == PH_STOP)) |-> !mc_en);

  p_wake_ring_r8: assert property (@(posedge clk) disable iff (rst)
    $past(wake_req && phase == PH_STOP) |-> on_ring);
endmodule

bind clk_rate_sel clk_rate_sel_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_mode  (wr_mode),
  .req_mode (req_mode),
  .err_clr  (err_clr),
  .err_flag (err_flag),
  .cur_mode (cur_mode),
  .mc_en    (mc_en),
  .pll_lock (pll_lock),
  .phase    (phase),
  .wake_req (wake_req),
  .on_ring  (on_ring)
);

// File: tb/clk_rate_sel_tb_top.sv
`timescale 1ns/1ps
module clk_rate_sel_tb_top;
  localparam int STAB_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_mode = 2'b10;
  logic err_clr = 1'b0;
  logic pll_lock = 1'b0;
  logic xtal_tick = 1'b0, pll2_tick = 1'b0, pll4_tick = 1'b0, ring_tick = 1'b0;
  logic stop_req = 1'b0, wake_req = 1'b0;
  logic [STAB_W-1:0] stable_cnt = 16'd20;
  logic mc_en, on_ring, err_flag;
  logic [1:0] cur_mode;

  always #5 clk = ~clk;

  clk_rate_sel #(.STD_DIV(4), .PMM_FACTOR(256), .STAB_W(STAB_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mode(wr_mode), .err_clr(err_clr),
    .pll_lock(pll_lock), .xtal_tick(xtal_tick), .pll2_tick(pll2_tick),
    .pll4_tick(pll4_tick), .ring_tick(ring_tick), .stop_req(stop_req),
    .wake_req(wake_req), .stable_cnt(stable_cnt), .mc_en(mc_en),
    .cur_mode(cur_mode), .on_ring(on_ring), .err_flag(err_flag)
  );

  int checks = 0;
  int errors = 0;
  int clk_cnt = 0;
  int last_pulse = 0;
  int pulse_n = 0;
  int ph = 0;
  bit xtal_on = 1'b1;
  bit done = 1'b0;

  typedef struct {
    logic [1:0] md;
    int         per;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // source tick generator: xtal every 4, 2X every 2, 4X every clk, ring every 3
  always @(negedge clk) begin
    ph = (ph == 11) ? 0 : ph + 1;
    xtal_tick = xtal_on && (ph % 4 == 0);
    pll2_tick = (ph % 2 == 0);
    pll4_tick = 1'b1;
    ring_tick = (ph % 3 == 0);
  end

  // monitor: pops expected machine cycles and compares period and mode
  always @(negedge clk) begin
    clk_cnt++;
    if (!rst && mc_en) begin
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.req, " period"}, clk_cnt - last_pulse, e.per);
        chk({e.req, " mode"}, int'(cur_mode), int'(e.md));
      end
      last_pulse = clk_cnt;
      pulse_n++;
    end
    if (clk_cnt > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", clk_cnt);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic push_exp(logic [1:0] md, int per, int n, int settle, string req);
    int s;
    s = pulse_n;
    wait (pulse_n >= s + settle);
    for (int i = 0; i < n; i++) sb_q.push_back('{md, per, req});
    wait (sb_q.size() == 0);
  endtask

  task automatic write_mode(logic [1:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_mode = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  initial begin
    int s, t0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 cur_mode", int'(cur_mode), 2);
    chk("R1 err_flag", int'(err_flag), 0);
    chk("R1 on_ring", int'(on_ring), 0);

    // R2: divide-by-4 default, 16 clocks per machine cycle
    push_exp(2'b10, 16, 3, 2, "R2 div4");

    // R2: slow mode, 1024 crystal ticks
    write_mode(2'b11);
    push_exp(2'b11, 4096, 2, 2, "R2 slow");

    // R3: direct slow -> 2X refused
    write_mode(2'b01);
    chk("R3 err set", int'(err_flag), 1);
    push_exp(2'b11, 4096, 1, 0, "R3 kept slow");
    // R4: sticky until cleared
    chk("R4 still set", int'(err_flag), 1);
    pulse_clr();
    @(negedge clk);
    chk("R4 cleared", int'(err_flag), 0);

    // R6: write mid-cycle, running slow cycle completes at full length
    s = pulse_n;
    wait (pulse_n > s);
    repeat (100) @(negedge clk);
    write_mode(2'b10);
    push_exp(2'b10, 4096, 1, 0, "R6 full old cycle");
    push_exp(2'b10, 16, 2, 2, "R2 back to div4");

    // R5: 4X requested without lock stays at div4
    write_mode(2'b00);
    chk("R5 legal write", int'(err_flag), 0);
    push_exp(2'b10, 16, 2, 2, "R5 no lock");
    pll_lock = 1'b1;
    push_exp(2'b00, 4, 3, 2, "R5 locked 4X");

    // R3: direct 4X -> 2X refused, R4 set wins over clear
    @(negedge clk);
    wr_en = 1'b1; wr_mode = 2'b01; err_clr = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; err_clr = 1'b0;
    chk("R4 set wins", int'(err_flag), 1);
    push_exp(2'b00, 4, 2, 0, "R3 kept 4X");
    pulse_clr();

    // R2: 2X via divide-by-4
    write_mode(2'b10);
    write_mode(2'b01);
    chk("R3 legal pair", int'(err_flag), 0);
    push_exp(2'b01, 8, 3, 2, "R2 2X");

    // R7: stop, crystal halted
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0; xtal_on = 1'b0;
    repeat (3) @(negedge clk);
    s = pulse_n;
    repeat (200) @(negedge clk);
    chk("R7 quiet in stop", pulse_n - s, 0);

    // R8: wake onto ring
    @(negedge clk); wake_req = 1'b1;
    @(negedge clk); wake_req = 1'b0;
    chk("R8 on_ring", int'(on_ring), 1);
    push_exp(2'b10, 12, 2, 2, "R8 ring div4");
    chk("R9 still ring", int'(on_ring), 1);

    // R9: crystal restarts, 20 ticks (80 clocks) before return
    xtal_on = 1'b1;
    t0 = clk_cnt;
    while (on_ring && clk_cnt - t0 < 2000) @(negedge clk);
    chk("R9 returned", int'(on_ring), 0);
    chk("R9 min stable window", int'(clk_cnt - t0 >= 80), 1);
    push_exp(2'b01, 8, 2, 2, "R9 back to 2X");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule